// File: doc/BRIEF.md
# External Chip Select Generator

This block turns the address and cycle-phase signals of an external bus controller into eight active-low chip-select strobes, one for each external address area. The area is taken from the three most significant bits of a 24-bit bus address. A strobe is asserted only while the controller reports an external cycle. It stays low through every state of that cycle and returns high on the edge after the cycle ends.

A small routing register set then places the area strobes on eight output pins. Each pin has a mask of source areas and an enable bit. A disabled pin behaves as an input: its output enable is low and its value is held high. A pin with several areas in its mask carries the merge of their strobes, so it goes low whenever any of those areas is accessed.

The reset value of the enable bits depends on a boot-mode input:
- With on-chip ROM disabled, only pin 0 comes out of reset driving.
- With on-chip ROM enabled, no pin comes out of reset driving.

The boot-mode input is read only during reset.

Top module: `cs_strobe_gen`

## Requirements
- R1: With `ext_cycle` high, the area is `bus_addr[23:21]`. On the next clock edge the strobe of that area, and every enabled pin whose mask has that area's bit set, goes low.
- R2: On the clock edge after a sample with `ext_cycle` low, every pin output is high, whatever the address.
- R3: A pin stays low on every edge while `ext_cycle` stays high on the same area. It rises on the edge after `ext_cycle` falls.
- R4: A pin whose enable bit is 0 has `cs_pin_oe` low and `cs_pin_n` high, even when an area in its mask is accessed.
- R5: After a reset with `boot_rom_en` = 0, `cs_pin_oe` is 8'h01. Each pin p is routed from area p alone (mask = 1 << p).
- R6: After a reset with `boot_rom_en` = 1, `cs_pin_oe` is 8'h00 and no pin goes low on any access. The routing is the same as in R5.
- R7: `boot_rom_en` is sampled only while `rst_n` is low. Changing it later leaves `cs_pin_oe` unchanged until the next reset.
- R8: Writing with `cfg_we` high loads the routing of pin `cfg_addr`: `cfg_data[7:0]` is the area mask (bit a = area a) and `cfg_data[8]` is the enable. The new routing governs the pins from the clock edge of the write. An access sampled on that same edge is routed with the new setting.
- R9: When a pin's mask holds several areas, the pin goes low on an access to any one of them and stays high for areas outside the mask.
- R10: At most one area strobe is active at any time, and only while an external cycle is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_rom_en | input | 1 | Boot mode: 1 = on-chip ROM enabled, 0 = disabled; read during reset |
| bus_addr | input | 24 | Address of the current bus cycle |
| ext_cycle | input | 1 | High while an external bus cycle is in progress |
| cfg_we | input | 1 | Routing register write strobe |
| cfg_addr | input | 3 | Index of the pin whose routing is written |
| cfg_data | input | 9 | {enable, area mask[7:0]} |
| cs_pin_n | output | 8 | Active-low chip-select pin values |
| cs_pin_oe | output | 8 | Per-pin output enable |

## Verification
A routing write and an external access can land on the same clock edge. The bench provokes this in two ways. First, it writes a new mask and enable for a pin in the same cycle as it presents an access to the newly routed area. Second, it disables a pin while that pin's area is being accessed. In both cases the pin is judged one edge later against a bench model that applies the write first: the new routing must already govern that access. Boot-mode changes during operation are also checked, to confirm they leave the enables alone.

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen #(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 8,
  parameter int N_PIN  = 8,
  localparam int SEL_W  = $clog2(N_AREA),
  localparam int CFG_AW = $clog2(N_PIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_rom_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ext_cycle,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [N_AREA:0]   cfg_data,
  output logic [N_PIN-1:0]  cs_pin_n,
  output logic [N_PIN-1:0]  cs_pin_oe
);

  logic [SEL_W-1:0]  area_sel;
  logic [N_AREA-1:0] area_d;
  logic [N_AREA-1:0] area_q;
  logic [N_AREA-1:0] mask_q [N_PIN];
  logic [N_PIN-1:0]  en_q;
  logic              addr_unused;

  assign area_sel    = bus_addr[ADDR_W-1 -: SEL_W];
  assign addr_unused = ^bus_addr[ADDR_W-SEL_W-1:0];

  for (genvar a = 0; a < N_AREA; a++) begin : g_area
    assign area_d[a] = ext_cycle && (area_sel == SEL_W'(a));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) area_q <= '0;
    else        area_q <= area_d;
  end

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[p] <= N_AREA'(1) << p;
        en_q[p]   <= (p == 0) ? !boot_rom_en : 1'b0;
      end else if (cfg_we && cfg_addr == CFG_AW'(p)) begin
        mask_q[p] <= cfg_data[N_AREA-1:0];
        en_q[p]   <= cfg_data[N_AREA];
      end
    end
    assign cs_pin_n[p] = ~(en_q[p] & |(area_q & mask_q[p]));
  end

  assign cs_pin_oe = en_q;

  a_r1_area_decode: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cycle |=> area_q == (N_AREA'(1) << $past(area_sel)));

  a_r2_idle_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cycle |=> &cs_pin_n);

  a_r10_one_area: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(area_q));

  a_r7_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cs_pin_oe));

endmodule

// File: tb/cs_strobe_gen_test.sv
module cs_strobe_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_rom_en = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        ext_cycle = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [8:0]  cfg_data = '0;
  logic [7:0]  cs_pin_n;
  logic [7:0]  cs_pin_oe;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mask [8];
  logic [7:0] m_en;

  always #2.5 clk = ~clk;

  cs_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .boot_rom_en(boot_rom_en), .bus_addr(bus_addr),
    .ext_cycle(ext_cycle), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cs_pin_n(cs_pin_n), .cs_pin_oe(cs_pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pins(input bit act, input int area);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) r[p] = !(act && m_en[p] && m_mask[p][area]);
    return r;
  endfunction

  task automatic do_reset(input bit boot);
    rst_n = 1'b0; boot_rom_en = boot; ext_cycle = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 8; p++) m_mask[p] = 8'(1 << p);
    m_en = boot ? 8'h00 : 8'h01;
  endtask

  task automatic cfg_write(input int pin, input bit en, input logic [7:0] mask);
    cfg_we = 1'b1; cfg_addr = 3'(pin); cfg_data = {en, mask};
    @(negedge clk);
    cfg_we = 1'b0;
    m_mask[pin] = mask; m_en[pin] = en;
  endtask

  task automatic access(input string req, input int area, input int len);
    for (int c = 0; c < len; c++) begin
      ext_cycle = 1'b1; bus_addr = {3'(area), 21'h0A5A5};
      @(negedge clk);
      chk(req, cs_pin_n, exp_pins(1'b1, area));
    end
    ext_cycle = 1'b0;
    @(negedge clk);
    chk({req, " end"}, cs_pin_n, 8'hFF);
  endtask

  task automatic t_reset_rom_off;
    do_reset(1'b0);
    chk("R5 oe", cs_pin_oe, 8'h01);
    chk("R5 pins", cs_pin_n, 8'hFF);
    access("R1 R3 area0", 0, 3);
    access("R4 area1 disabled", 1, 2);
    chk("R4 oe", cs_pin_oe, 8'h01);
  endtask

  task automatic t_boot_hold;
    boot_rom_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 oe after boot change", cs_pin_oe, 8'h01);
    access("R7 area0 still drives", 0, 1);
    boot_rom_en = 1'b0;
  endtask

  task automatic t_idle;
    for (int a = 0; a < 8; a++) begin
      ext_cycle = 1'b0; bus_addr = {3'(a), 21'h1};
      @(negedge clk);
      chk("R2 idle", cs_pin_n, 8'hFF);
    end
  endtask

  task automatic t_all_pins;
    for (int p = 0; p < 8; p++) cfg_write(p, 1'b1, 8'(1 << p));
    chk("R8 oe all", cs_pin_oe, 8'hFF);
    for (int a = 0; a < 8; a++) access("R1 R8 R10 area", a, 1);
  endtask

  task automatic t_merge;
    cfg_write(3, 1'b1, 8'b0110_0000);
    access("R9 area5", 5, 2);
    access("R9 area6", 6, 1);
    access("R9 area3 outside", 3, 1);
  endtask

  task automatic t_same_cycle;
    ext_cycle = 1'b1; bus_addr = {3'd7, 21'h0};
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_data = {1'b1, 8'h80};
    m_mask[2] = 8'h80; m_en[2] = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 same-edge write", cs_pin_n, exp_pins(1'b1, 7));
    cfg_we = 1'b1; cfg_addr = 3'd7; cfg_data = {1'b0, 8'h80};
    m_en[7] = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R4 R8 disable mid-cycle", cs_pin_n, exp_pins(1'b1, 7));
    chk("R4 oe pin7", cs_pin_oe, m_en);
    ext_cycle = 1'b0;
    @(negedge clk);
    chk("R3 release", cs_pin_n, 8'hFF);
  endtask

  task automatic t_reset_rom_on;
    do_reset(1'b1);
    chk("R6 oe", cs_pin_oe, 8'h00);
    for (int a = 0; a < 8; a++) access("R6 no strobe", a, 1);
    cfg_write(4, 1'b1, 8'h10);
    access("R6 R8 enabled after write", 4, 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_rom_off();
    t_boot_hold();
    t_idle();
    t_all_pins();
    t_merge();
    t_same_cycle();
    t_reset_rom_on();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule